// File: doc/BRIEF.md
# Asynchronous Serial Byte Receiver with Framing-Error Reporting

This block recovers bytes from an asynchronous serial line. It watches the line for a falling edge. It checks that the start bit is real. It then gathers eight data bits, least significant bit first, and tests the stop bit. Every bit is timed by an oversampling tick that runs at sixteen times the bit rate. Near the middle of each bit the block takes three samples and keeps the majority value. This filters out single-tick noise.

When a frame finishes, the byte moves into the data register and the ready flag rises. If the stop bit was low, the framing-error flag rises in the same cycle. The byte is delivered even in that case. A break, where the line stays low for the whole frame, is reported through the same flag. Software tells a break apart from a framing error by reading the byte: a value of 00h means break.

The interrupt request follows the ready flag only. Software clears both flags with a fixed two-step sequence: a status read followed by a data read. A data read without a preceding status read leaves the flags untouched.

Top module: `uart_rx_fe`

## Requirements
- R1: After reset, rx_ready, frame_err and irq are 0 and rx_byte is 00h.
- R2: A frame of one low start bit, eight data bits (first bit on the line goes to rx_byte[0]) and one stop bit, each bit 16 os_tick periods long, is delivered as rx_byte with rx_ready set once per frame.
- R3: Each bit is decided by a majority of the samples at oversample counts 7, 8 and 9 of the bit, so a line glitch of one tick period inside a bit does not change the received value.
- R4: A low pulse that is high again at the middle of the start bit is discarded: the receiver returns to idle and no byte is delivered.
- R5: A stop bit sampled low sets frame_err in the same clock cycle that rx_ready rises, and the shifted byte is still loaded into rx_byte.
- R6: A break (line low for the whole frame) sets frame_err and delivers rx_byte = 00h.
- R7: irq is high exactly while rx_ready is high; frame_err never requests an interrupt on its own and is never set while rx_ready is low.
- R8: A status-read strobe followed later by a data-read strobe clears rx_ready, frame_err and irq.
- R9: A data-read strobe with no status-read strobe since the previous data read leaves rx_ready and frame_err unchanged.
- R10: While en is low the receiver stays idle and ignores the line; no byte is delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Receiver enable |
| os_tick | input | 1 | One-cycle strobe at 16x the bit rate |
| rxd | input | 1 | Serial line, idle high |
| stat_rd | input | 1 | Strobe marking a read of the status register |
| data_rd | input | 1 | Strobe marking a read of the data register |
| rx_byte | output | 8 | Last received byte |
| rx_ready | output | 1 | Received-data-ready flag |
| frame_err | output | 1 | Framing-error flag (missing stop bit or break) |
| irq | output | 1 | Interrupt request, driven by the ready flag only |

## Verification
The bench sends bytes with a low stop bit and sends a full break. A design that drops the byte on an error, or sets the error flag a cycle away from the ready flag, shows up as a wrong byte or a wrong flag at the moment ready rises.

Other stimuli cover the noise filter and the start check. A one-tick glitch placed inside a data bit catches a receiver that decides on a single sample. A short low pulse catches one that fails to abandon a false start.

The bench also covers the flag handling and the enable. It issues a lone data read, then the proper status-then-data sequence. A design that clears on any data read, or never clears, is caught. A frame sent while the receiver is disabled must produce nothing.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2,
        ST_STOP  = 2'd3
    } rx_state_e;

    typedef struct packed {
        logic early;
        logic centre;
    } samp_s;

    function automatic logic majority3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/rx_bit_sampler.sv
module rx_bit_sampler
    import uart_rx_pkg::*;
#(
    parameter int OVERSAMPLE = 16,
    localparam int CW = $clog2(OVERSAMPLE)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [CW-1:0] cnt,
    input  logic          line,
    output logic          vote,
    output logic          vote_ok
);
    localparam int MID = OVERSAMPLE / 2;
    localparam logic [CW-1:0] PT_EARLY  = CW'(MID - 1);
    localparam logic [CW-1:0] PT_CENTRE = CW'(MID);
    localparam logic [CW-1:0] PT_LATE   = CW'(MID + 1);

    samp_s smp_d, smp_q;

    always_comb begin
        smp_d = smp_q;
        if (tick && cnt == PT_EARLY)  smp_d.early  = line;
        if (tick && cnt == PT_CENTRE) smp_d.centre = line;
        vote_ok = tick && (cnt == PT_LATE);
        vote    = majority3(smp_q.early, smp_q.centre, line);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) smp_q <= '{early: 1'b1, centre: 1'b1};
        else        smp_q <= smp_d;
    end
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
    import uart_rx_pkg::*;
#(
    parameter int DATA_BITS  = 8,
    parameter int OVERSAMPLE = 16,
    localparam int CW = $clog2(OVERSAMPLE),
    localparam int BW = $clog2(DATA_BITS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 tick,
    input  logic                 line,
    input  logic                 vote,
    input  logic                 vote_ok,
    output logic [CW-1:0]        cnt,
    output logic                 done,
    output logic                 stop_bad,
    output logic [DATA_BITS-1:0] shifted
);
    localparam logic [CW-1:0] CNT_LAST = CW'(OVERSAMPLE - 1);
    localparam logic [BW-1:0] BIT_LAST = BW'(DATA_BITS - 1);

    typedef struct packed {
        rx_state_e            state;
        logic [CW-1:0]        cnt;
        logic [BW-1:0]        bit_idx;
        logic [DATA_BITS-1:0] shreg;
    } fsm_s;

    fsm_s f_d, f_q;

    always_comb begin
        f_d      = f_q;
        done     = 1'b0;
        stop_bad = 1'b0;
        if (!en) begin
            f_d.state = ST_IDLE;
            f_d.cnt   = '0;
        end else if (tick) begin
            if (f_q.state == ST_IDLE) begin
                if (!line) begin
                    f_d.state = ST_START;
                    f_d.cnt   = '0;
                end
            end else begin
                f_d.cnt = f_q.cnt + 1'b1;
                if (f_q.cnt == CNT_LAST) begin
                    if (f_q.state == ST_START) begin
                        f_d.state   = ST_DATA;
                        f_d.bit_idx = '0;
                    end else if (f_q.state == ST_DATA) begin
                        if (f_q.bit_idx == BIT_LAST) f_d.state = ST_STOP;
                        else f_d.bit_idx = f_q.bit_idx + 1'b1;
                    end
                end
                if (vote_ok) begin
                    unique case (f_q.state)
                        ST_START: if (vote) f_d.state = ST_IDLE;
                        ST_DATA:  f_d.shreg = {vote, f_q.shreg[DATA_BITS-1:1]};
                        ST_STOP: begin
                            done      = 1'b1;
                            stop_bad  = !vote;
                            f_d.state = ST_IDLE;
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '{state: ST_IDLE, cnt: '0, bit_idx: '0, shreg: '0};
        else        f_q <= f_d;
    end

    assign cnt     = f_q.cnt;
    assign shifted = f_q.shreg;
endmodule

// File: rtl/rx_status_regs.sv
module rx_status_regs #(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 done,
    input  logic                 stop_bad,
    input  logic [DATA_BITS-1:0] shifted,
    input  logic                 stat_rd,
    input  logic                 data_rd,
    output logic [DATA_BITS-1:0] data,
    output logic                 ready,
    output logic                 ferr
);
    typedef struct packed {
        logic [DATA_BITS-1:0] data;
        logic                 ready;
        logic                 ferr;
        logic                 armed;
    } stat_s;

    stat_s s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (data_rd && s_q.armed) begin
            s_d.ready = 1'b0;
            s_d.ferr  = 1'b0;
        end
        if (stat_rd)      s_d.armed = 1'b1;
        else if (data_rd) s_d.armed = 1'b0;
        if (done) begin
            s_d.data  = shifted;
            s_d.ready = 1'b1;
            s_d.ferr  = s_d.ferr | stop_bad;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{data: '0, ready: 1'b0, ferr: 1'b0, armed: 1'b0};
        else        s_q <= s_d;
    end

    assign data  = s_q.data;
    assign ready = s_q.ready;
    assign ferr  = s_q.ferr;
endmodule

// File: rtl/uart_rx_fe.sv
module uart_rx_fe #(
    parameter int DATA_BITS   = 8,
    parameter int OVERSAMPLE  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 os_tick,
    input  logic                 rxd,
    input  logic                 stat_rd,
    input  logic                 data_rd,
    output logic [DATA_BITS-1:0] rx_byte,
    output logic                 rx_ready,
    output logic                 frame_err,
    output logic                 irq
);
    localparam int CW = $clog2(OVERSAMPLE);

    logic                 line_s;
    logic [CW-1:0]        cnt;
    logic                 vote, vote_ok;
    logic                 done, stop_bad;
    logic [DATA_BITS-1:0] shifted;

    rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(rxd), .dout(line_s)
    );

    rx_bit_sampler #(.OVERSAMPLE(OVERSAMPLE)) u_samp (
        .clk(clk), .rst_n(rst_n), .tick(os_tick), .cnt(cnt),
        .line(line_s), .vote(vote), .vote_ok(vote_ok)
    );

    rx_frame_fsm #(.DATA_BITS(DATA_BITS), .OVERSAMPLE(OVERSAMPLE)) u_fsm (
        .clk(clk), .rst_n(rst_n), .en(en), .tick(os_tick), .line(line_s),
        .vote(vote), .vote_ok(vote_ok), .cnt(cnt), .done(done),
        .stop_bad(stop_bad), .shifted(shifted)
    );

    rx_status_regs #(.DATA_BITS(DATA_BITS)) u_stat (
        .clk(clk), .rst_n(rst_n), .done(done), .stop_bad(stop_bad),
        .shifted(shifted), .stat_rd(stat_rd), .data_rd(data_rd),
        .data(rx_byte), .ready(rx_ready), .ferr(frame_err)
    );

    assign irq = rx_ready;
endmodule

// File: rtl/uart_rx_fe_checker.sv
module uart_rx_fe_checker (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic stat_rd,
    input logic data_rd,
    input logic rx_ready,
    input logic frame_err
);
    logic seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       seen_q <= 1'b0;
        else if (stat_rd) seen_q <= 1'b1;
        else if (data_rd) seen_q <= 1'b0;
    end

    AST_FE_RISES_WITH_READY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_err) |-> rx_ready); // R5

    AST_FE_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |-> rx_ready); // R7

    AST_LONE_DATA_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !seen_q) |=> (!$fell(rx_ready) && !$fell(frame_err))); // R9

    AST_READY_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_ready) |-> $past(en)); // R10
endmodule

bind uart_rx_fe uart_rx_fe_checker u_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .stat_rd(stat_rd), .data_rd(data_rd),
    .rx_ready(rx_ready), .frame_err(frame_err)
);

// File: tb/uart_rx_fe_bench.sv
module uart_rx_fe_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       os_tick = 1'b0;
    logic       rxd = 1'b1;
    logic       stat_rd = 1'b0;
    logic       data_rd = 1'b0;
    logic [7:0] rx_byte;
    logic       rx_ready, frame_err, irq;

    int checks = 0;
    int fails  = 0;
    bit done_flag = 0;
    logic [1:0] div = '0;
    logic [8:0] expq[$];
    logic prev_rdy = 1'b0;

    always #10 clk = ~clk;

    always_ff @(posedge clk) begin
        div     <= div + 2'd1;
        os_tick <= (div == 2'd3);
    end

    uart_rx_fe u_uart_rx_fe (
        .clk(clk), .rst_n(rst_n), .en(en), .os_tick(os_tick), .rxd(rxd),
        .stat_rd(stat_rd), .data_rd(data_rd), .rx_byte(rx_byte),
        .rx_ready(rx_ready), .frame_err(frame_err), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step_tick();
        repeat (4) @(negedge clk);
    endtask

    // glitch_at: tick step within data bit 3 to invert (-1 = none)
    task automatic drive_frame(input logic [7:0] b, input logic stop, input int glitch_at);
        logic [9:0] bits;
        bits = {stop, b, 1'b0};
        for (int i = 0; i < 10; i++)
            for (int t = 0; t < 16; t++) begin
                rxd = (i == 4 && t == glitch_at) ? ~bits[i] : bits[i];
                step_tick();
            end
        rxd = 1'b1;
        repeat (32) step_tick();
    endtask

    task automatic send(input logic [7:0] b, input logic stop, input int glitch_at,
                        input logic [7:0] exp_b, input logic exp_fe);
        expq.push_back({exp_fe, exp_b});
        drive_frame(b, stop, glitch_at);
    endtask

    task automatic clear_seq();
        @(negedge clk); stat_rd = 1'b1;
        @(negedge clk); stat_rd = 1'b0; data_rd = 1'b1;
        @(negedge clk); data_rd = 1'b0;
        check(!rx_ready && !frame_err && !irq, "R8 clear", {rx_ready, frame_err, irq}, 0);
    endtask

    // Monitor: compares each delivered byte against the scoreboard
    always @(negedge clk) begin
        if (rst_n && rx_ready && !prev_rdy) begin
            if (expq.size() == 0) begin
                check(0, "R4/R10 unexpected byte", rx_byte, 0);
            end else begin
                logic [8:0] e;
                e = expq.pop_front();
                check(rx_byte == e[7:0], "R2 byte", rx_byte, e[7:0]);
                check(frame_err == e[8], "R5 frame_err with ready", frame_err, e[8]);
                check(irq == 1'b1, "R7 irq with ready", irq, 1);
            end
        end
        prev_rdy = rx_ready;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            checks++; fails++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        check(!rx_ready && !frame_err && !irq && rx_byte == 8'h00, "R1 reset",
              {rx_byte, rx_ready, frame_err, irq}, 0);
        rst_n = 1'b1;
        en    = 1'b1;
        repeat (8) @(negedge clk);

        send(8'h55, 1'b1, -1, 8'h55, 1'b0);                 // R2
        clear_seq();
        send(8'h81, 1'b1, -1, 8'h81, 1'b0);                 // R2
        clear_seq();
        send(8'hB6, 1'b1, 9, 8'hB6, 1'b0);                  // R3 glitch in bit 3
        clear_seq();
        send(8'h4F, 1'b1, 9, 8'h4F, 1'b0);                  // R3 glitch, bit 3 = 1
        clear_seq();
        send(8'hA5, 1'b0, -1, 8'hA5, 1'b1);                 // R5 stop low
        check(frame_err && irq, "R7 irq only from ready", irq, 1);
        // R9: lone data read keeps flags
        @(negedge clk); data_rd = 1'b1;
        @(negedge clk); data_rd = 1'b0;
        repeat (2) @(negedge clk);
        check(rx_ready && frame_err, "R9 lone data read", {rx_ready, frame_err}, 3);
        clear_seq();
        // R6: break
        send(8'h00, 1'b0, -1, 8'h00, 1'b1);
        check(rx_byte == 8'h00 && frame_err, "R6 break", {rx_byte, frame_err}, 1);
        clear_seq();
        // R4: false start, low only 3 ticks
        rxd = 1'b0; repeat (3) step_tick();
        rxd = 1'b1; repeat (200) step_tick();
        check(!rx_ready, "R4 false start", rx_ready, 0);
        // R10: disabled receiver
        en = 1'b0;
        drive_frame(8'h3C, 1'b1, -1);
        check(!rx_ready, "R10 disabled", rx_ready, 0);
        en = 1'b1;
        repeat (4) step_tick();
        send(8'hFF, 1'b1, -1, 8'hFF, 1'b0);                 // R2 after enable
        clear_seq();
        send(8'h00, 1'b1, -1, 8'h00, 1'b0);                 // R2 zero byte, good stop
        clear_seq();
        check(expq.size() == 0, "R2 all frames delivered", expq.size(), 0);

        done_flag = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule